// File: doc/BRIEF.md
# Cache Replacement Way Selector

This block decides which way of a set-associative cache (one to four ways) gets overwritten when a miss has to be refilled. The cache controller reports every hit (line index and hit way) and every refill (line index and filled way). When it needs a victim, it presents the line index together with that line's per-way lock bits, and the block answers combinationally with the way to evict. It raises a separate flag when every way of the line is locked.

The policy is fixed by a parameter. The first policy is a free-running counter. The second is least-recently-replaced, which keeps one bit per line and is legal only with two ways. The third is least-recently-used, which holds per line an ordering of the ways in 1, 3 or 5 bits for 2, 3 or 4 ways. With one way the cache is direct-mapped and the answer is always way 0. Tag and data arrays, hit detection and the refill sequencer belong to the surrounding controller.

Top module: `evict_way_sel`

## Requirements
- R1: With WAYS=1 the victim is always way 0. The no-victim flag is high only when locking is enabled and lock bit 0 is set.
- R2: The counter policy uses a counter of 1 bit for 2 ways and 2 bits for 3 or 4 ways. The counter is 0 after reset and advances by one every clock, wrapping from WAYS-1 to 0. With no locks the victim equals the counter.
- R3: The replaced-order policy (POLICY=1) keeps one bit per line. After way w of a line is filled, the victim for that line is the other way. Any configuration other than WAYS=2 for this policy raises an error at elaboration.
- R4: Under the replaced-order policy, hits never change the victim of any line.
- R5: Under the LRU policy (POLICY=2), both hits and fills make the touched way the most recent. The victim is the way touched longest ago, and after reset the age order is way 0 oldest up to way WAYS-1 newest.
- R6: Replacement state is kept per line: events on one line leave the victim of every other line unchanged.
- R7: A hit and a fill in the same cycle are both applied. On the same line the hit is applied first and the fill second, so the filled way ends most recent.
- R8: Lock bit i covers way i, and a locked way is never returned. If the policy's choice is locked, the next unlocked way is taken. Under LRU this is the next older-to-newer way. Under the other policies it is the next higher way index, wrapping to 0.
- R9: When every way of the presented line is locked (and locking is enabled), the no-victim flag is 1 and the victim output is 0.
- R10: With LOCK_EN=0 the lock inputs have no effect: the flag stays 0 and the victim is that of the policy.
- R11: After reset every line's victim is way 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A hit occurred this cycle |
| acc_line | input | $clog2(LINES) | Line index of the hit |
| acc_way | input | max(1,$clog2(WAYS)) | Way that hit |
| fill_valid | input | 1 | A refill is written this cycle |
| fill_line | input | $clog2(LINES) | Line index of the refill |
| fill_way | input | max(1,$clog2(WAYS)) | Way being refilled |
| q_line | input | $clog2(LINES) | Line for which a victim is requested |
| q_lock | input | WAYS | Lock bits of that line, bit i for way i |
| victim_way | output | max(1,$clog2(WAYS)) | Way to evict |
| no_victim | output | 1 | Every way of the line is locked |

## Verification
A hit and a refill can land in the same cycle, either on one line or on two different lines. The bench provokes both cases on the four-way LRU instance. On a shared line it touches way 1 and fills way 0 together. It then judges the result through two further hits: the first victim must be way 2, and after the hits the victim must be way 1, which shows the hit was ordered before the fill. On distinct lines, each line must show its own update independently.

// File: rtl/evict_way_sel.sv
module evict_way_sel #(
  parameter int WAYS    = 4,
  parameter int LINES   = 16,
  parameter int POLICY  = 2,
  parameter int LOCK_EN = 1
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic                                    acc_valid,
  input  logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] acc_line,
  input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]   acc_way,
  input  logic                                    fill_valid,
  input  logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] fill_line,
  input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]   fill_way,
  input  logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] q_line,
  input  logic [WAYS-1:0]                         q_lock,
  output logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]   victim_way,
  output logic                                    no_victim
);
  localparam int IW    = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int WW    = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int LRU_W = (WAYS == 4) ? 5 : (WAYS == 3) ? 3 : 1;

  if (WAYS < 1 || WAYS > 4 || POLICY < 0 || POLICY > 2 || (POLICY == 1 && WAYS != 2)) begin : g_bad_cfg
    initial $error("evict_way_sel: unsupported WAYS/POLICY combination");
  end

  logic [3:0][1:0] pref;
  logic [3:0]      lk4;
  logic            unused_lock;

  assign lk4         = (LOCK_EN != 0) ? 4'(q_lock) : 4'b0;
  assign unused_lock = ^q_lock;

  function automatic logic [3:0][1:0] lru_dec(input logic [4:0] code);
    logic [3:0][1:0] ord;
    logic [3:0]      used;
    int pos, d, cnt, n, w;
    ord  = '0;
    used = '0;
    pos  = 0;
    for (int i = 0; i < WAYS; i++) begin
      n = WAYS - i;
      w = (n > 2) ? 2 : 1;
      d = 0;
      if (n > 1) begin
        d   = int'((code >> pos) & ((5'd1 << w) - 5'd1));
        pos = pos + w;
      end
      if (d > n - 1) d = n - 1;
      cnt = 0;
      for (int k = 0; k < WAYS; k++) begin
        if (!used[k]) begin
          if (cnt == d) ord[i] = 2'(k);
          cnt++;
        end
      end
      used[ord[i]] = 1'b1;
    end
    return ord;
  endfunction

  function automatic logic [4:0] lru_enc(input logic [3:0][1:0] ord);
    logic [4:0] code;
    logic [3:0] used;
    int pos, d, n;
    code = '0;
    used = '0;
    pos  = 0;
    for (int i = 0; i < WAYS; i++) begin
      n = WAYS - i;
      d = 0;
      for (int k = 0; k < WAYS; k++)
        if (!used[k] && k < int'(ord[i])) d++;
      if (n > 1) begin
        code = code | (5'(d) << pos);
        pos  = pos + ((n > 2) ? 2 : 1);
      end
      used[ord[i]] = 1'b1;
    end
    return code;
  endfunction

  function automatic logic [4:0] lru_touch(input logic [4:0] code, input logic [1:0] way);
    logic [3:0][1:0] ord, nord;
    int j;
    ord  = lru_dec(code);
    nord = '0;
    j    = 0;
    for (int i = 0; i < WAYS; i++) begin
      if (ord[i] != way && j < WAYS - 1) begin
        nord[j] = ord[i];
        j++;
      end
    end
    nord[WAYS-1] = way;
    return lru_enc(nord);
  endfunction

  if (WAYS == 1) begin : g_dm
    logic unused_dm;
    assign unused_dm = ^{clk, rst_n, acc_valid, acc_line, acc_way,
                         fill_valid, fill_line, fill_way, q_line};
    assign pref = '0;
  end else if (POLICY == 2) begin : g_lru
    logic [LRU_W-1:0] lru_q [LINES];
    logic [4:0]       a_nxt, f_base, f_nxt;

    assign a_nxt  = lru_touch(5'(lru_q[acc_line]), 2'(acc_way));
    assign f_base = (acc_valid && acc_line == fill_line) ? a_nxt : 5'(lru_q[fill_line]);
    assign f_nxt  = lru_touch(f_base, 2'(fill_way));
    assign pref   = lru_dec(5'(lru_q[q_line]));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int l = 0; l < LINES; l++) lru_q[l] <= '0;
      end else begin
        if (acc_valid)  lru_q[acc_line]  <= LRU_W'(a_nxt);
        if (fill_valid) lru_q[fill_line] <= LRU_W'(f_nxt);
      end
    end
  end else begin : g_ptr
    logic [WW-1:0] cand;

    always_comb begin
      pref = '0;
      for (int i = 0; i < WAYS; i++) pref[i] = 2'((int'(cand) + i) % WAYS);
    end

    if (POLICY == 1) begin : g_lrr
      logic lrr_q [LINES];
      logic unused_lrr;
      assign unused_lrr = ^{acc_valid, acc_line, acc_way, fill_way};
      assign cand = WW'(lrr_q[q_line]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int l = 0; l < LINES; l++) lrr_q[l] <= 1'b0;
        end else if (fill_valid) begin
          lrr_q[fill_line] <= ~fill_way[0];
        end
      end
    end else begin : g_rnd
      logic [WW-1:0] rnd_q;
      logic          unused_rnd;
      assign unused_rnd = ^{acc_valid, acc_line, acc_way, fill_valid, fill_line,
                            fill_way, q_line};
      assign cand = rnd_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      rnd_q <= '0;
        else if (rnd_q == WW'(WAYS - 1)) rnd_q <= '0;
        else                             rnd_q <= rnd_q + 1'b1;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    no_victim  = 1'b1;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!lk4[pref[i]]) begin
        victim_way = WW'(pref[i]);
        no_victim  = 1'b0;
      end
    end
  end
endmodule

// File: rtl/evict_way_sel_chk.sv
module evict_way_sel_chk #(
  parameter int WAYS    = 4,
  parameter int LINES   = 16,
  parameter int POLICY  = 2,
  parameter int LOCK_EN = 1
) (
  input logic                                    clk,
  input logic                                    rst_n,
  input logic                                    acc_valid,
  input logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] acc_line,
  input logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]   acc_way,
  input logic                                    fill_valid,
  input logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] fill_line,
  input logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]   fill_way,
  input logic [((LINES > 1) ? $clog2(LINES) : 1)-1:0] q_line,
  input logic [WAYS-1:0]                         q_lock,
  input logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0]   victim_way,
  input logic                                    no_victim
);
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [3:0] lk4;
  logic       all_locked;
  logic       unused_chk;
  assign lk4        = 4'(q_lock);
  assign all_locked = (LOCK_EN != 0) && (&q_lock);
  assign unused_chk = ^{acc_valid, acc_line, acc_way, fill_valid, fill_line, fill_way, q_line};

  p_victim_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (LOCK_EN != 0 && !no_victim) |-> !lk4[victim_way]);

  p_victim_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(victim_way) < WAYS);

  p_full_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    all_locked |-> (no_victim && victim_way == '0));

  p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    no_victim |-> all_locked);

  if (LOCK_EN == 0) begin : g_nolock
    p_lock_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !no_victim);
  end

  if (WAYS == 1) begin : g_dm
    p_dm_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      victim_way == '0);
  end else if (POLICY == 2) begin : g_lru
    p_lru_recent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(acc_valid) && !$past(fill_valid) &&
       q_line == $past(acc_line) && (LOCK_EN == 0 || q_lock == '0))
      |-> victim_way != $past(acc_way));
  end else if (POLICY == 1) begin : g_lrr
    p_lrr_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fill_valid) && q_line == $past(fill_line) &&
       (LOCK_EN == 0 || q_lock == '0))
      |-> victim_way != $past(fill_way));
    p_lrr_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(fill_valid) && $stable(q_line) && $stable(q_lock))
      |-> $stable(victim_way));
  end else begin : g_rnd
    p_rnd_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && (LOCK_EN == 0 || (q_lock == '0 && $past(q_lock) == '0)))
      |-> victim_way == (($past(victim_way) == WW'(WAYS - 1)) ? '0 : $past(victim_way) + 1'b1));
  end
endmodule

bind evict_way_sel evict_way_sel_chk #(
  .WAYS(WAYS), .LINES(LINES), .POLICY(POLICY), .LOCK_EN(LOCK_EN)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .acc_valid(acc_valid), .acc_line(acc_line), .acc_way(acc_way),
  .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way),
  .q_line(q_line), .q_lock(q_lock),
  .victim_way(victim_way), .no_victim(no_victim)
);

// File: tb/test_evict_way_sel.sv
module test_evict_way_sel;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, fill_valid = 1'b0;
  logic [2:0] acc_line = '0, fill_line = '0, q_line = '0;
  logic [1:0] acc_way = '0, fill_way = '0;
  logic [3:0] lk4 = '0;
  logic [2:0] lk3 = '0;
  logic [1:0] lk2 = '0;
  logic [0:0] lk1 = '0;
  logic [1:0] v4, v3l, v3r;
  logic [0:0] v2, v1;
  logic       n4, n3l, n3r, n2, n1;
  int         n_chk = 0, n_err = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evict_way_sel #(.WAYS(4), .LINES(8), .POLICY(2), .LOCK_EN(1)) i_evict_way_sel (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line), .acc_way(acc_way),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way),
    .q_line(q_line), .q_lock(lk4), .victim_way(v4), .no_victim(n4));

  evict_way_sel #(.WAYS(3), .LINES(8), .POLICY(2), .LOCK_EN(1)) i_lru3 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line), .acc_way(acc_way),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way),
    .q_line(q_line), .q_lock(lk3), .victim_way(v3l), .no_victim(n3l));

  evict_way_sel #(.WAYS(2), .LINES(8), .POLICY(1), .LOCK_EN(0)) i_lrr2 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line), .acc_way(acc_way[0:0]),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way[0:0]),
    .q_line(q_line), .q_lock(lk2), .victim_way(v2), .no_victim(n2));

  evict_way_sel #(.WAYS(3), .LINES(8), .POLICY(0), .LOCK_EN(1)) i_rnd3 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line), .acc_way(acc_way),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way),
    .q_line(q_line), .q_lock(lk3), .victim_way(v3r), .no_victim(n3r));

  evict_way_sel #(.WAYS(1), .LINES(8), .POLICY(2), .LOCK_EN(1)) i_dm1 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line), .acc_way(acc_way[0:0]),
    .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(fill_way[0:0]),
    .q_line(q_line), .q_lock(lk1), .victim_way(v1), .no_victim(n1));

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    acc_valid = 1'b0; fill_valid = 1'b0;
    lk4 = '0; lk3 = '0; lk2 = '0; lk1 = '0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hit(input int line, input int way);
    @(negedge clk);
    acc_valid = 1'b1; acc_line = 3'(line); acc_way = 2'(way);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic fill(input int line, input int way);
    @(negedge clk);
    fill_valid = 1'b1; fill_line = 3'(line); fill_way = 2'(way);
    @(negedge clk);
    fill_valid = 1'b0;
  endtask

  task automatic peek(input int line);
    q_line = 3'(line);
    #1;
  endtask

  task automatic t_reset_r11();
    do_reset();
    for (int l = 0; l < 8; l += 3) begin
      peek(l);
      check("R11 lru4 victim after reset", int'(v4), 0);
      check("R11 lru4 flag after reset", int'(n4), 0);
      check("R11 lru3 victim after reset", int'(v3l), 0);
      check("R11 lrr2 victim after reset", int'(v2), 0);
    end
  endtask

  task automatic t_lru4_r5_r6();
    do_reset();
    hit(3, 0);  peek(3); check("R5 lru4 after hit w0", int'(v4), 1);
    hit(3, 2);  peek(3); check("R5 lru4 after hit w2", int'(v4), 1);
    hit(3, 1);  peek(3); check("R5 lru4 after hit w1", int'(v4), 3);
    fill(3, 3); peek(3); check("R5 lru4 fill counts as use", int'(v4), 0);
    hit(5, 0);
    peek(5); check("R6 lru4 other line updated", int'(v4), 1);
    peek(3); check("R6 lru4 line 3 untouched", int'(v4), 0);
    lk4 = 4'b0001; peek(3); check("R8 lru4 skip locked oldest", int'(v4), 2);
    lk4 = 4'b0101; peek(3); check("R8 lru4 skip two locked", int'(v4), 1);
    lk4 = 4'b0111; peek(3); check("R8 lru4 only newest free", int'(v4), 3);
    check("R8 lru4 flag low with one free", int'(n4), 0);
    lk4 = 4'b1111; peek(3);
    check("R9 lru4 flag all locked", int'(n4), 1);
    check("R9 lru4 victim zero all locked", int'(v4), 0);
    lk4 = 4'b0000;
  endtask

  task automatic t_same_cycle_r7();
    do_reset();
    @(negedge clk);
    acc_valid = 1'b1; acc_line = 3'd2; acc_way = 2'd1;
    fill_valid = 1'b1; fill_line = 3'd2; fill_way = 2'd0;
    @(negedge clk);
    acc_valid = 1'b0; fill_valid = 1'b0;
    peek(2); check("R7 same line hit+fill", int'(v4), 2);
    hit(2, 2); hit(2, 3);
    peek(2); check("R7 hit ordered before fill", int'(v4), 1);
    @(negedge clk);
    acc_valid = 1'b1; acc_line = 3'd6; acc_way = 2'd0;
    fill_valid = 1'b1; fill_line = 3'd7; fill_way = 2'd0;
    @(negedge clk);
    acc_valid = 1'b0; fill_valid = 1'b0;
    peek(6); check("R7 distinct lines hit side", int'(v4), 1);
    peek(7); check("R7 distinct lines fill side", int'(v4), 1);
  endtask

  task automatic t_lru3_r5();
    do_reset();
    hit(1, 0); peek(1); check("R5 lru3 hit w0", int'(v3l), 1);
    hit(1, 1); peek(1); check("R5 lru3 hit w1", int'(v3l), 2);
    hit(1, 2); peek(1); check("R5 lru3 hit w2", int'(v3l), 0);
    hit(1, 1); peek(1); check("R5 lru3 hit w1 again", int'(v3l), 0);
    hit(1, 0); peek(1); check("R5 lru3 hit w0 again", int'(v3l), 2);
    lk3 = 3'b100; peek(1); check("R8 lru3 skip locked", int'(v3l), 1);
    lk3 = 3'b000;
  endtask

  task automatic t_lrr_r3_r4_r10();
    do_reset();
    peek(4);    check("R3 lrr initial", int'(v2), 0);
    fill(4, 0); peek(4); check("R3 lrr fill w0", int'(v2), 1);
    hit(4, 1);  hit(4, 1); peek(4); check("R4 lrr hits on w1 ignored", int'(v2), 1);
    hit(4, 0);  peek(4); check("R4 lrr hit on w0 ignored", int'(v2), 1);
    fill(4, 1); peek(4); check("R3 lrr fill w1", int'(v2), 0);
    fill(4, 1); peek(4); check("R3 lrr repeat fill w1", int'(v2), 0);
    peek(5);    check("R6 lrr other line", int'(v2), 0);
    fill(4, 0);
    lk2 = 2'b11; peek(4);
    check("R10 lrr locks ignored flag", int'(n2), 0);
    check("R10 lrr locks ignored victim", int'(v2), 1);
    lk2 = 2'b10; peek(4); check("R10 lrr lock on victim ignored", int'(v2), 1);
    lk2 = 2'b00;
  endtask

  task automatic t_rnd_r2();
    int k;
    acc_valid = 1'b0; fill_valid = 1'b0; lk3 = '0;
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; #1;
    k = 0;
    check("R2 rnd starts at zero", int'(v3r), 0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1; k++;
      check("R2 rnd steps every cycle", int'(v3r), k % 3);
    end
    lk3 = 3'b010;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1; k++;
      check("R8 rnd skips locked way upward", int'(v3r), ((k % 3) == 1) ? 2 : (k % 3));
    end
    lk3 = 3'b110;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1; k++;
      check("R8 rnd wraps to way 0", int'(v3r), 0);
    end
    lk3 = 3'b111; #1;
    check("R9 rnd all locked flag", int'(n3r), 1);
    check("R9 rnd all locked victim", int'(v3r), 0);
    lk3 = 3'b000;
  endtask

  task automatic t_dm_r1();
    do_reset();
    peek(2); check("R1 dm victim", int'(v1), 0);
    check("R1 dm flag unlocked", int'(n1), 0);
    hit(2, 0); fill(2, 0); peek(2); check("R1 dm after events", int'(v1), 0);
    lk1 = 1'b1; peek(2);
    check("R1 dm flag locked", int'(n1), 1);
    check("R1 dm victim locked", int'(v1), 0);
    lk1 = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset_r11();
    t_lru4_r5_r6();
    t_same_cycle_r7();
    t_lru3_r5();
    t_lrr_r3_r4_r10();
    t_rnd_r2();
    t_dm_r1();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule